// File: doc/BRIEF.md
# Write-Back Cache Store Buffer

This block is the store path of a direct-mapped data cache that keeps modified lines only in the cache. Each line holds one word. Memory sees a line only when it is evicted. A store never writes the data array in its own lookup cycle. In that cycle it reads the tag, valid and dirty state and places its word and byte enables into a one-entry buffer. When the lookup hits, the buffered word is written into the data array in the next cycle in which the processor does not claim the array. The processor therefore pays one cycle per store hit. It never waits for a separate write cycle, and a dirty line that has no copy in memory cannot be damaged by a store that later turns out to miss.

A miss holds the processor off while a small controller talks to memory. In state LOOKUP the cache serves requests. The transition LOOKUP→EVICT is taken when a miss finds its victim valid and dirty. The transition LOOKUP→REFILL is taken when the victim is clean or invalid. EVICT→REFILL follows the memory acknowledge of the write-back. REFILL→LOOKUP follows the acknowledge of the line read, and on that edge the line is installed. Misses are write-allocate: after the refill, the buffered store is merged into the arriving line and the line is marked dirty. A load to the word that the buffer holds is answered from the buffer, merged over the array copy. Any other request made while the buffer is full waits exactly one cycle while the buffer drains.

Top module: `wb_store_cache`

## Requirements
- R1: A store never alters a line before its tag check. When a store misses on a dirty line, the word written back is the line's content from before that store.
- R2: A load or store that hits raises `cpu_done` for one cycle, in the cycle after the one in which it was accepted (`cpu_req` and `cpu_ready` both high at a rising edge).
- R3: A load returns the most recent data stored to its word address. Data from a store hit is committed in the first cycle after acceptance in which no request is accepted.
- R4: While the buffer holds a store hit, any request other than a matching load sees `cpu_ready` low for exactly one cycle, then is accepted.
- R5: A load whose word address equals that of the buffered store hit is accepted with no stall. It returns the buffered bytes merged over the array word.
- R6: Bit i of `cpu_be` selects data bits 8i+7..8i. Bytes whose enable is low keep their previous value.
- R7: A miss whose victim is valid and dirty first issues a memory write (`mem_we`=1) of the victim at address {victim tag, index}. It then issues the line read. Request, address and direction are held until `mem_ack`.
- R8: A miss whose victim is clean or invalid issues only the line read, with no memory write.
- R9: A store miss refills the line, merges the store into it under its byte enables, and leaves the line dirty. A later eviction writes the merged word back.
- R10: A hit issues no memory request. Memory is written only on eviction.
- R11: A load miss returns the refilled word with `cpu_done`, one cycle after the `mem_ack` of the line read.
- R12: After reset every line is invalid and clean, `cpu_ready` is high, and `cpu_done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_waddr | input | WADDR_W | Word address; low IDX_W bits are the index, the rest the tag |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_ready | output | 1 | Request is accepted at this edge |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` and held until the next completion |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write-back, 0 = line read |
| mem_addr | output | WADDR_W | Line (word) address for memory |
| mem_wdata | output | DATA_W | Victim data for write-back |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Line data, valid with `mem_ack` on a read |

## Verification
A dirty flag left unset, or a store that reaches the array before its hit is known, appears at `mem_wdata` at the next eviction of that index. The written-back word differs from the expected line, or an expected write-back is missing altogether. A buffer that fails to drain or forward appears at `cpu_rdata` on the very next load to that word, or as a stall count other than one on the request directly behind a store hit. Wrong victim handling is reported at the end of the miss that exposes it, by counting memory writes and reads against a reference model of every line's tag, valid and dirty state.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        S_LOOKUP = 2'd0,
        S_EVICT  = 2'd1,
        S_REFILL = 2'd2
    } cb_state_e;

endpackage

// File: rtl/cbs_tag_array.sv
module cbs_tag_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic [TAG_W-1:0] mark_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
            end
            if (mark_en) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // a drained store may only touch a line that is present with its tag
    AST_DRAIN_LINE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> (valid_q[mark_idx] && tag_q[mark_idx] == mark_tag)); // R1

endmodule

// File: rtl/cbs_data_array.sv
module cbs_data_array #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int BE_W  = DATA_W / 8;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        logic [7:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_q[wr_idx] <= wr_data[8*b +: 8];
            end
        end

        assign rd_data[8*b +: 8] = lane_q[rd_idx];
    end

endmodule

// File: rtl/cbs_store_buf.sv
module cbs_store_buf #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                load_hold,
    input  logic [IDX_W-1:0]    load_idx,
    input  logic [TAG_W-1:0]    load_tag,
    input  logic [DATA_W-1:0]   load_data,
    input  logic [DATA_W/8-1:0] load_be,
    input  logic                clear_en,
    input  logic [DATA_W-1:0]   merge_base,
    output logic                valid,
    output logic                hold,
    output logic [IDX_W-1:0]    idx,
    output logic [TAG_W-1:0]    tag,
    output logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   merged
);
    localparam int BE_W = DATA_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            hold  <= 1'b0;
        end else if (load_en) begin
            valid <= 1'b1;
            hold  <= load_hold;
        end else if (clear_en) begin
            valid <= 1'b0;
            hold  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            idx  <= load_idx;
            tag  <= load_tag;
            data <= load_data;
            be   <= load_be;
        end
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[8*b +: 8] = be[b] ? data[8*b +: 8] : merge_base[8*b +: 8];
    end

    // a waiting store is never overwritten by a newer one
    AST_BUF_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !valid); // R4

endmodule

// File: rtl/wb_store_cache.sv
module wb_store_cache
    import cbs_pkg::*;
#(
    parameter int WADDR_W = 14,
    parameter int IDX_W   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [WADDR_W-1:0]  cpu_waddr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W/8-1:0] cpu_be,
    output logic                cpu_ready,
    output logic                cpu_done,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int TAG_W = WADDR_W - IDX_W;
    localparam int BE_W  = DATA_W / 8;

    cb_state_e state_q, state_d;

    logic               rq_we_q;
    logic [WADDR_W-1:0] rq_addr_q;

    logic [IDX_W-1:0]  cpu_idx, rq_idx, arr_idx;
    logic [TAG_W-1:0]  cpu_tag, rq_tag, t_tag;
    logic              t_valid, t_dirty;
    logic [DATA_W-1:0] d_rdata, d_wdata, merge_base, merged;
    logic              d_we;
    logic [IDX_W-1:0]  d_idx;
    logic [BE_W-1:0]   d_be;

    logic              sb_valid, sb_hold;
    logic [IDX_W-1:0]  sb_idx;
    logic [TAG_W-1:0]  sb_tag;
    logic [DATA_W-1:0] sb_data;
    logic [BE_W-1:0]   sb_be;

    logic hit, fwd, accept, drain, fill_done;

    assign cpu_idx = cpu_waddr[IDX_W-1:0];
    assign cpu_tag = cpu_waddr[WADDR_W-1:IDX_W];
    assign rq_idx  = rq_addr_q[IDX_W-1:0];
    assign rq_tag  = rq_addr_q[WADDR_W-1:IDX_W];
    assign arr_idx = (state_q == S_LOOKUP) ? cpu_idx : rq_idx;

    assign hit = t_valid && (t_tag == cpu_tag);
    assign fwd = sb_valid && !sb_hold && !cpu_we && (sb_idx == cpu_idx) && (sb_tag == cpu_tag);

    cbs_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (arr_idx),
        .rd_tag     (t_tag),
        .rd_valid   (t_valid),
        .rd_dirty   (t_dirty),
        .fill_en    (fill_done),
        .fill_idx   (rq_idx),
        .fill_tag   (rq_tag),
        .fill_dirty (rq_we_q),
        .mark_en    (drain),
        .mark_idx   (sb_idx),
        .mark_tag   (sb_tag)
    );

    cbs_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (arr_idx),
        .rd_data (d_rdata),
        .wr_en   (d_we),
        .wr_idx  (d_idx),
        .wr_be   (d_be),
        .wr_data (d_wdata)
    );

    cbs_store_buf #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_sbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (accept && cpu_we),
        .load_hold  (!hit),
        .load_idx   (cpu_idx),
        .load_tag   (cpu_tag),
        .load_data  (cpu_wdata),
        .load_be    (cpu_be),
        .clear_en   (drain || fill_done),
        .merge_base (merge_base),
        .valid      (sb_valid),
        .hold       (sb_hold),
        .idx        (sb_idx),
        .tag        (sb_tag),
        .data       (sb_data),
        .be         (sb_be),
        .merged     (merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        accept    = 1'b0;
        drain     = 1'b0;
        fill_done = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rq_addr_q;
        mem_wdata = d_rdata;
        unique case (state_q)
            S_LOOKUP: begin
                cpu_ready = !(sb_valid && !fwd);
                accept    = cpu_req && cpu_ready;
                drain     = sb_valid && !sb_hold && !accept;
                if (accept && !hit) begin
                    state_d = (t_valid && t_dirty) ? S_EVICT : S_REFILL;
                end
            end
            S_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {t_tag, rq_idx};
                if (mem_ack) begin
                    state_d = S_REFILL;
                end
            end
            S_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_done = 1'b1;
                    state_d   = S_LOOKUP;
                end
            end
            default: begin
                state_d = S_LOOKUP;
            end
        endcase
    end

    // array write port: a drained store hit or an installed line
    assign merge_base = (state_q == S_REFILL) ? mem_rdata : d_rdata;
    assign d_we       = drain || fill_done;
    assign d_idx      = fill_done ? rq_idx : sb_idx;
    assign d_be       = fill_done ? {BE_W{1'b1}} : sb_be;
    assign d_wdata    = fill_done ? (rq_we_q ? merged : mem_rdata) : sb_data;

    // request capture and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we_q   <= 1'b0;
            rq_addr_q <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done <= (accept && hit) || fill_done;
            if (accept) begin
                rq_we_q   <= cpu_we;
                rq_addr_q <= cpu_waddr;
            end
            if (accept && hit) begin
                cpu_rdata <= fwd ? merged : d_rdata;
            end else if (fill_done) begin
                cpu_rdata <= mem_rdata;
            end
        end
    end

    AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOOKUP && cpu_req && !cpu_ready) |=> !sb_valid); // R4

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> !mem_req); // R10

    AST_WB_THEN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R7

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7

endmodule

// File: tb/sim_wb_store_cache.sv
`timescale 1ns/1ps
module sim_wb_store_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [13:0] cpu_waddr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready, cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wb_store_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int compared = 0;
    int mismatched = 0;

    // reference state: 4 tags x 16 indices are used
    logic [31:0] gold [64];
    logic [31:0] bmem [64];
    bit          mvalid [16];
    bit          mdirty [16];
    int          mtag [16];
    bit          buf_pending = 0;
    int          buf_line = 0;

    int          wb_count = 0, rd_count = 0;
    logic [13:0] last_wb_addr = '0;
    logic [31:0] last_wb_data = '0;

    function automatic logic [31:0] init_val(int l);
        return 32'h5A00_0000 ^ (32'(l) * 32'h0103_0507);
    endfunction

    function automatic logic [31:0] bmerge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
        return r;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // memory responder with random latency
    initial begin
        int lat;
        lat = 1;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wb_count++;
                        last_wb_addr = mem_addr;
                        last_wb_data = mem_wdata;
                        bmem[mem_addr[5:0]] = mem_wdata;
                    end else begin
                        rd_count++;
                        mem_rdata = bmem[mem_addr[5:0]];
                    end
                    lat = int'($urandom_range(0, 2));
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic access(bit we, int t, int i, logic [31:0] d, logic [3:0] be, int gap);
        int l, vl, stalls, wb0, rd0;
        bit hit, fwd, exp_stall, exp_wb;
        logic [31:0] vgold;
        l = t * 16 + i;
        if (gap > 0) buf_pending = 0;
        hit = mvalid[i] && mtag[i] == t;
        fwd = !we && buf_pending && buf_line == l;
        exp_stall = buf_pending && !fwd;
        exp_wb = !hit && mvalid[i] && mdirty[i];
        vl = mtag[i] * 16 + i;
        vgold = gold[vl];
        wb0 = wb_count;
        rd0 = rd_count;
        repeat (gap) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_waddr = 14'(l); cpu_wdata = d; cpu_be = be;
        stalls = 0;
        #1;
        while (!cpu_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        if (hit) chk("R2 done one cycle after hit", 32'(cpu_done), 32'd1);
        else while (!cpu_done) @(negedge clk);
        chk(fwd ? "R5 no stall on forwarded load" : "R4 stall cycles", 32'(stalls), exp_stall ? 32'd1 : 32'd0);
        chk(hit ? "R10 no memory read on hit" : "R11 one line read", 32'(rd_count - rd0), hit ? 32'd0 : 32'd1);
        chk(exp_wb ? "R7 write-back count" : "R8 no write-back", 32'(wb_count - wb0), exp_wb ? 32'd1 : 32'd0);
        if (exp_wb) begin
            chk("R7 victim address", 32'(last_wb_addr), 32'(vl));
            chk("R1 victim data predates store", last_wb_data, vgold);
        end
        if (!we) chk(fwd ? "R5 forwarded data" : "R3 load data", cpu_rdata, gold[l]);
        if (we) gold[l] = bmerge(gold[l], d, be);
        if (hit) mdirty[i] = mdirty[i] | we;
        else begin mvalid[i] = 1; mtag[i] = t; mdirty[i] = we; end
        if (we && hit) begin buf_pending = 1; buf_line = l; end
        else if (!fwd) buf_pending = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] exp;
        void'($urandom(32'd4242));
        for (int l = 0; l < 64; l++) begin gold[l] = init_val(l); bmem[l] = init_val(l); end
        for (int i = 0; i < 16; i++) begin mvalid[i] = 0; mdirty[i] = 0; mtag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready after reset", 32'(cpu_ready), 32'd1);
        chk("R12 done low after reset", 32'(cpu_done), 32'd0);
        chk("R12 no memory request after reset", 32'(mem_req), 32'd0);

        access(0, 0, 0, 0, 4'h0, 0);                 // R11 R8 clean load miss
        access(1, 0, 0, 32'hDEAD_BEEF, 4'hF, 0);     // R2 store hit
        access(0, 0, 0, 0, 4'h0, 0);                 // R5 forward
        access(0, 0, 1, 0, 4'h0, 0);                 // R4 stall, miss
        access(1, 0, 1, 32'h1122_3344, 4'b0101, 1);  // R6 partial store
        access(0, 0, 1, 0, 4'h0, 1);                 // R3 after drain
        exp = bmerge(init_val(1), 32'h1122_3344, 4'b0101);
        chk("R6 byte-enable merge", cpu_rdata, exp);
        access(1, 1, 0, 32'hCAFE_0000, 4'b1100, 0);  // R1 R7 R9 store miss on dirty
        access(0, 1, 0, 0, 4'h0, 2);
        exp = bmerge(init_val(16), 32'hCAFE_0000, 4'b1100);
        chk("R9 allocated line holds merged store", cpu_rdata, exp);
        access(0, 2, 0, 0, 4'h0, 0);                 // R9 eviction of merged line
        chk("R9 merged word written back", last_wb_data, exp);
        access(0, 3, 2, 0, 4'h0, 0);
        access(0, 0, 2, 0, 4'h0, 0);                 // R8 clean eviction

        for (int k = 0; k < 400; k++) begin
            access(bit'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                   $urandom, 4'(($urandom % 15) + 1), int'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule